// File: doc/BRIEF.md
# Indexed Vector Gather/Scatter Address Unit

This unit carries out indexed vector memory operations for a vector processor. A command names an operation, a vector length, a scalar base address and up to three vector registers. In a gather, each element of an index register is added to the base. One word is read from memory at each resulting address, and the returned words land in consecutive elements of a destination register. In a scatter, element i of a data register is written to memory at the base plus element i of the index register.

The unit sits between a vector register file and a word memory. It reads the register file through two combinational read ports, one for indices and one for store data. It writes gather results through a single write port. Toward memory it drives a request that the memory accepts with a grant in the same cycle. Read data returns in request order after any latency, marked by a valid strobe. A one-cycle done pulse tells the issuing logic that the command has completed.

Top module: `vgs_unit`

## Requirements
- R1: A gather with vector length VL writes memory word (base + index[i]) into destination element i for every i below VL.
- R2: A scatter with vector length VL writes data element i into memory word (base + index[i]) for every i below VL.
- R3: Destination elements at or beyond VL keep their values. Memory words not addressed by an element below VL keep their values. A gather never changes memory.
- R4: The address is the latched base plus the low ADDR_W bits of the index, taken as unsigned, modulo 2^ADDR_W. Requests go out in ascending element order, at most one accepted per cycle. A request not granted stays asserted with the same element. mem_we is 1 for scatter requests and 0 for gather requests.
- R5: Gather results are written back in ascending element order. A write-back occurs in the same cycle that mem_rvalid is high, to the latched destination register, with wr_elem counting up from 0.
- R6: When several scatter elements target the same address, the value of the highest-numbered element remains in memory.
- R7: done is high for exactly one cycle. It rises in the cycle after the last element completes, which is the grant of the last write for a scatter and the last read return for a gather. busy is low while done is high and afterwards.
- R8: A command with VL of 0 raises done in the cycle after start is sampled, issues no memory request and performs no register write.
- R9: start is ignored while busy or done is high. Inputs changed during a command have no effect on it.
- R10: A scatter never writes the register file.
- R11: A VL greater than MVL processes exactly MVL elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a command (sampled when idle) |
| op_scatter | input | 1 | 1 = scatter, 0 = gather |
| vl | input | VL_W | Vector length for the command |
| base | input | ADDR_W | Scalar base address |
| idx_reg | input | REG_W | Index vector register number |
| data_reg | input | REG_W | Scatter data vector register number |
| dst_reg | input | REG_W | Gather destination vector register number |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ia_reg | output | REG_W | Index read port register select |
| ia_elem | output | ELEM_W | Index read port element select |
| ia_data | input | DATA_W | Index read port data (combinational) |
| da_reg | output | REG_W | Data read port register select |
| da_elem | output | ELEM_W | Data read port element select |
| da_data | input | DATA_W | Data read port data (combinational) |
| wr_en | output | 1 | Register file write enable |
| wr_reg | output | REG_W | Register file write register |
| wr_elem | output | ELEM_W | Register file write element |
| wr_data | output | DATA_W | Register file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid, in request order |
| mem_rdata | input | DATA_W | Read data |

## Verification
mem_req, mem_addr and mem_wdata change in the cycle after the start edge and after every granted edge. The bench reads them at each falling edge and matches every granted request against the next expected element address. A write-back appears combinationally in the cycle mem_rvalid is high, so it is checked at the falling edge of that same cycle. done is due exactly one cycle after the falling edge at which the bench saw the last completion, or one cycle after the start edge when VL is 0. The bench records the completion in one cycle and requires done in the next, then compares the whole memory and register file with arithmetically computed copies one cycle after done.

// File: rtl/vgs_pkg.sv
// Shared types for the indexed vector gather/scatter unit.
// Assumes nothing beyond a two-valued enum encoding.
package vgs_pkg;

    // Command sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } vgs_state_e;

    // Operation kind latched for the running command
    typedef enum logic {
        OP_GATHER  = 1'b0,
        OP_SCATTER = 1'b1
    } vgs_op_e;

endpackage

// File: rtl/vgs_agen.sv
// Element address generator: adds the low address bits of an index word
// to the latched base address, wrapping modulo 2^ADDR_W.
// Assumes the index is an unsigned quantity.
module vgs_agen #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DATA_W-1:0] index,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] idx_part;

    // Fit the index word to the address width
    generate
        if (DATA_W >= ADDR_W) begin : g_slice
            assign idx_part = index[ADDR_W-1:0];
        end else begin : g_extend
            assign idx_part = {{(ADDR_W-DATA_W){1'b0}}, index};
        end
    endgenerate

    // Wrapping sum of base and index
    always_comb begin
        addr = base + idx_part;
    end

endmodule

// File: rtl/vgs_ctrl.sv
// Command controller: accepts a command when idle, latches its fields,
// counts issued elements, and sequences IDLE -> RUN -> FIN -> IDLE.
// Assumes memory grants in the cycle of the request and that gather
// completion is reported by the write-back stage.
module vgs_ctrl
    import vgs_pkg::*;
#(
    parameter  int ADDR_W = 10,
    parameter  int MVL    = 8,
    parameter  int NREG   = 4,
    localparam int VL_W   = $clog2(MVL + 1),
    localparam int ELEM_W = $clog2(MVL),
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_scatter,
    input  logic [VL_W-1:0]   vl,
    input  logic [ADDR_W-1:0] base,
    input  logic [REG_W-1:0]  idx_reg,
    input  logic [REG_W-1:0]  data_reg,
    input  logic [REG_W-1:0]  dst_reg,
    input  logic              mem_gnt,
    input  logic              gather_last,
    output logic              busy,
    output logic              done,
    output logic              clear,
    output vgs_op_e           op_q,
    output logic [VL_W-1:0]   vl_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [REG_W-1:0]  idx_q,
    output logic [REG_W-1:0]  data_q,
    output logic [REG_W-1:0]  dst_q,
    output logic [ELEM_W-1:0] iss_elem,
    output logic              mem_req
);

    localparam logic [VL_W-1:0] MVL_V = VL_W'(MVL);

    vgs_state_e      state_q;
    logic [VL_W-1:0] iss_q;
    logic [VL_W-1:0] vl_eff;
    logic [VL_W-1:0] vl_m1;
    logic            start_acc;
    logic            accept;
    logic            finish;

    // Clamp the requested length to the register length
    always_comb begin
        vl_eff = (vl > MVL_V) ? MVL_V : vl;
    end

    // Handshake and completion terms
    always_comb begin
        start_acc = start && (state_q == ST_IDLE);
        busy      = (state_q == ST_RUN);
        done      = (state_q == ST_FIN);
        mem_req   = busy && (iss_q < vl_q);
        accept    = mem_req && mem_gnt;
        vl_m1     = vl_q - VL_W'(1);
        if (op_q == OP_SCATTER) begin
            finish = accept && (iss_q == vl_m1);
        end else begin
            finish = gather_last;
        end
        clear    = start_acc;
        iss_elem = iss_q[ELEM_W-1:0];
    end

    // Sequencing state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start_acc) state_q <= (vl_eff == '0) ? ST_FIN : ST_RUN;
                ST_RUN:  if (finish)    state_q <= ST_FIN;
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Command field capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_GATHER;
            vl_q   <= '0;
            base_q <= '0;
            idx_q  <= '0;
            data_q <= '0;
            dst_q  <= '0;
        end else if (start_acc) begin
            op_q   <= op_scatter ? OP_SCATTER : OP_GATHER;
            vl_q   <= vl_eff;
            base_q <= base;
            idx_q  <= idx_reg;
            data_q <= data_reg;
            dst_q  <= dst_reg;
        end
    end

    // Issued-element counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_q <= '0;
        end else if (start_acc) begin
            iss_q <= '0;
        end else if (accept) begin
            iss_q <= iss_q + VL_W'(1);
        end
    end

endmodule

// File: rtl/vgs_wb.sv
// Gather write-back stage: maps each in-order read return onto the next
// destination element and flags the final return of the command.
// Assumes returns arrive in request order and only for issued reads.
module vgs_wb #(
    parameter  int DATA_W = 32,
    parameter  int MVL    = 8,
    parameter  int NREG   = 4,
    localparam int VL_W   = $clog2(MVL + 1),
    localparam int ELEM_W = $clog2(MVL),
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              enable,
    input  logic [VL_W-1:0]   vl_q,
    input  logic [REG_W-1:0]  dst_q,
    input  logic              rvalid,
    input  logic [DATA_W-1:0] rdata,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic [ELEM_W-1:0] wr_elem,
    output logic [DATA_W-1:0] wr_data,
    output logic              last
);

    logic [VL_W-1:0] ret_q;

    // Register file write and last-return detection
    always_comb begin
        wr_en   = enable && rvalid;
        wr_reg  = dst_q;
        wr_elem = ret_q[ELEM_W-1:0];
        wr_data = rdata;
        last    = wr_en && (ret_q == (vl_q - VL_W'(1)));
    end

    // Returned-element counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (clear) begin
            ret_q <= '0;
        end else if (wr_en) begin
            ret_q <= ret_q + VL_W'(1);
        end
    end

endmodule

// File: rtl/vgs_unit.sv
// Indexed vector gather/scatter unit top level. Connects the controller,
// the address generator and the gather write-back stage to a register
// file with two combinational read ports and one write port, and to a
// word memory with same-cycle grant and in-order read returns.
// Assumes the gather destination differs from the index register.
module vgs_unit
    import vgs_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int ADDR_W = 10,
    parameter  int MVL    = 8,
    parameter  int NREG   = 4,
    localparam int VL_W   = $clog2(MVL + 1),
    localparam int ELEM_W = $clog2(MVL),
    localparam int REG_W  = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_scatter,
    input  logic [VL_W-1:0]   vl,
    input  logic [ADDR_W-1:0] base,
    input  logic [REG_W-1:0]  idx_reg,
    input  logic [REG_W-1:0]  data_reg,
    input  logic [REG_W-1:0]  dst_reg,
    output logic              busy,
    output logic              done,
    output logic [REG_W-1:0]  ia_reg,
    output logic [ELEM_W-1:0] ia_elem,
    input  logic [DATA_W-1:0] ia_data,
    output logic [REG_W-1:0]  da_reg,
    output logic [ELEM_W-1:0] da_elem,
    input  logic [DATA_W-1:0] da_data,
    output logic              wr_en,
    output logic [REG_W-1:0]  wr_reg,
    output logic [ELEM_W-1:0] wr_elem,
    output logic [DATA_W-1:0] wr_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    vgs_op_e           op_q;
    logic [VL_W-1:0]   vl_q;
    logic [ADDR_W-1:0] base_q;
    logic [REG_W-1:0]  idx_q;
    logic [REG_W-1:0]  data_q;
    logic [REG_W-1:0]  dst_q;
    logic [ELEM_W-1:0] iss_elem;
    logic              clear;
    logic              gather_last;
    logic              wb_enable;

    vgs_ctrl #(
        .ADDR_W (ADDR_W),
        .MVL    (MVL),
        .NREG   (NREG)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .op_scatter  (op_scatter),
        .vl          (vl),
        .base        (base),
        .idx_reg     (idx_reg),
        .data_reg    (data_reg),
        .dst_reg     (dst_reg),
        .mem_gnt     (mem_gnt),
        .gather_last (gather_last),
        .busy        (busy),
        .done        (done),
        .clear       (clear),
        .op_q        (op_q),
        .vl_q        (vl_q),
        .base_q      (base_q),
        .idx_q       (idx_q),
        .data_q      (data_q),
        .dst_q       (dst_q),
        .iss_elem    (iss_elem),
        .mem_req     (mem_req)
    );

    vgs_agen #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_agen (
        .base  (base_q),
        .index (ia_data),
        .addr  (mem_addr)
    );

    vgs_wb #(
        .DATA_W (DATA_W),
        .MVL    (MVL),
        .NREG   (NREG)
    ) u_wb (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .enable  (wb_enable),
        .vl_q    (vl_q),
        .dst_q   (dst_q),
        .rvalid  (mem_rvalid),
        .rdata   (mem_rdata),
        .wr_en   (wr_en),
        .wr_reg  (wr_reg),
        .wr_elem (wr_elem),
        .wr_data (wr_data),
        .last    (gather_last)
    );

    // Register file read selection and memory write qualifiers
    always_comb begin
        ia_reg    = idx_q;
        ia_elem   = iss_elem;
        da_reg    = data_q;
        da_elem   = iss_elem;
        mem_we    = mem_req && (op_q == OP_SCATTER);
        mem_wdata = da_data;
        wb_enable = busy && (op_q == OP_GATHER);
    end

endmodule

// File: rtl/vgs_unit_chk.sv
// Protocol checker for vgs_unit, attached by bind. Observes only ports.
module vgs_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic mem_req,
    input logic mem_we,
    input logic mem_gnt,
    input logic wr_en
);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !mem_req && !wr_en));

    // R4
    req_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req);

    // R10
    scatter_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !wr_en);

endmodule

bind vgs_unit vgs_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_gnt (mem_gnt),
    .wr_en   (wr_en)
);

// File: tb/vgs_unit_bench.sv
// Self-checking bench: register file and memory models, two grant
// patterns, sweeps over every vector length with computed expectations.
module vgs_unit_bench;

    localparam int DW   = 32;
    localparam int AW   = 10;
    localparam int MVL  = 8;
    localparam int NREG = 4;
    localparam int VLW  = $clog2(MVL + 1);
    localparam int EW   = $clog2(MVL);
    localparam int RW   = $clog2(NREG);
    localparam int MSZ  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          op_scatter = 1'b0;
    logic [VLW-1:0] vl = '0;
    logic [AW-1:0] base = '0;
    logic [RW-1:0] idx_reg = '0, data_reg = '0, dst_reg = '0;
    logic          busy, done;
    logic [RW-1:0] ia_reg, da_reg, wr_reg;
    logic [EW-1:0] ia_elem, da_elem, wr_elem;
    logic [DW-1:0] ia_data, da_data, wr_data;
    logic          wr_en, mem_req, mem_we, mem_gnt, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    logic [DW-1:0] mem [MSZ];
    logic [DW-1:0] rf [NREG][MVL];
    logic [DW-1:0] xmem [MSZ];
    logic [DW-1:0] xrf [NREG][MVL];

    logic          gnt_all = 1'b1;
    logic [7:0]    lfsr = 8'hA5;
    logic          rv1 = 1'b0, rv2 = 1'b0;
    logic [DW-1:0] rd1 = '0, rd2 = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vgs_unit #(.DATA_W(DW), .ADDR_W(AW), .MVL(MVL), .NREG(NREG)) u_vgs_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op_scatter(op_scatter),
        .vl(vl), .base(base), .idx_reg(idx_reg), .data_reg(data_reg),
        .dst_reg(dst_reg), .busy(busy), .done(done),
        .ia_reg(ia_reg), .ia_elem(ia_elem), .ia_data(ia_data),
        .da_reg(da_reg), .da_elem(da_elem), .da_data(da_data),
        .wr_en(wr_en), .wr_reg(wr_reg), .wr_elem(wr_elem), .wr_data(wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    assign ia_data    = rf[ia_reg][ia_elem];
    assign da_data    = rf[da_reg][da_elem];
    assign mem_gnt    = gnt_all | lfsr[0];
    assign mem_rvalid = rv2;
    assign mem_rdata  = rd2;

    // Memory model: same-cycle grant, two-cycle in-order read latency
    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;
        rv1  <= mem_req && mem_gnt && !mem_we;
        rd1  <= mem[mem_addr];
        rv2  <= rv1;
        rd2  <= rd1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end

    // Register file write port model
    always @(posedge clk) begin
        if (wr_en) rf[wr_reg][wr_elem] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Run one command and check requests, write-backs, done timing, final state
    task automatic run_op(input bit scat, input int vlin, input int bs,
                          input int ir, input int dr, input int ds,
                          input bit poke, input string req);
        int vle = (vlin > MVL) ? MVL : vlin;
        logic [AW-1:0] ea [MVL];
        int k = 0, wk = 0, errs = 0, werrs = 0, mm = 0, rm = 0;
        bit comp_prev, comp_now, fin = 1'b0, late = 1'b0;
        for (int a = 0; a < MSZ; a++) xmem[a] = mem[a];
        for (int r = 0; r < NREG; r++)
            for (int e = 0; e < MVL; e++) xrf[r][e] = rf[r][e];
        for (int e = 0; e < vle; e++) begin
            ea[e] = AW'(bs + int'(rf[ir][e][AW-1:0]));
            if (scat) xmem[ea[e]] = rf[dr][e];
            else      xrf[ds][e]  = mem[ea[e]];
        end
        @(negedge clk);
        op_scatter = scat; vl = VLW'(vlin); base = AW'(bs);
        idx_reg = RW'(ir); data_reg = RW'(dr); dst_reg = RW'(ds);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        comp_prev = (vle == 0);
        for (int c = 0; c < 400 && !fin; c++) begin
            if (done) begin
                late = !comp_prev;
                fin  = 1'b1;
            end else begin
                comp_now = 1'b0;
                if (comp_prev) late = 1'b1;
                if (mem_req && mem_gnt) begin
                    if (k >= vle || mem_addr != ea[k] || mem_we != scat ||
                        (scat && mem_wdata != rf[dr][k])) errs++;
                    if (scat && k == vle - 1) comp_now = 1'b1;
                    k++;
                end
                if (wr_en) begin
                    if (scat || wk >= vle || int'(wr_elem) != wk ||
                        int'(wr_reg) != ds || wr_data != xrf[ds][wk]) werrs++;
                    if (wk == vle - 1) comp_now = 1'b1;
                    wk++;
                end
                comp_prev = comp_now;
                if (poke && c == 1) begin
                    start = 1'b1; op_scatter = !scat; vl = VLW'(MVL);
                    base = base + AW'(5); dst_reg = RW'(ir);
                end else if (poke && c == 2) begin
                    start = 1'b0;
                end
                @(negedge clk);
            end
        end
        start = 1'b0;
        chk(fin, "R7", {req, " done seen"}, fin, 1);
        chk(!late, "R7", {req, " done one cycle after last completion"}, late, 0);
        chk(k == vle, "R4", {req, " accepted request count"}, k, vle);
        chk(errs == 0, "R4", {req, " request order and address"}, errs, 0);
        chk(wk == (scat ? 0 : vle), scat ? "R10" : "R5",
            {req, " write-back count"}, wk, scat ? 0 : vle);
        chk(werrs == 0, "R5", {req, " write-back order and data"}, werrs, 0);
        @(negedge clk);
        chk(!done && !busy, "R9", {req, " idle after done"}, {done, busy}, 0);
        for (int a = 0; a < MSZ; a++) if (mem[a] != xmem[a]) mm++;
        for (int r = 0; r < NREG; r++)
            for (int e = 0; e < MVL; e++) if (rf[r][e] != xrf[r][e]) rm++;
        chk(mm == 0, scat ? "R2" : "R3", {req, " memory image"}, mm, 0);
        chk(rm == 0, scat ? "R10" : "R1", {req, " register image"}, rm, 0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int a = 0; a < MSZ; a++) mem[a] = DW'(a * 7 + 3);
        for (int r = 0; r < NREG; r++)
            for (int e = 0; e < MVL; e++) rf[r][e] = 32'hDEAD_0000 + DW'(r * 16 + e);
        repeat (5) @(negedge clk);
        chk(!busy && !done && !mem_req && !wr_en, "R7", "reset outputs quiet",
            {busy, done, mem_req, wr_en}, 0);
        rst_n = 1'b1;

        // Worked gather/scatter case
        mem[100] = 200; mem[101] = 300; mem[102] = 400; mem[103] = 500;
        mem[104] = 600; mem[105] = 700; mem[106] = 100; mem[107] = 250;
        mem[108] = 350;
        rf[0][0] = 4; rf[0][1] = 2; rf[0][2] = 7; rf[0][3] = 0;
        rf[2][0] = 200; rf[2][1] = 300; rf[2][2] = 400; rf[2][3] = 500;
        run_op(1'b0, 4, 100, 0, 2, 1, 1'b0, "R1 case gather");
        chk(rf[1][0] == 600, "R1", "element 0 of gather", rf[1][0], 600);
        chk(rf[1][3] == 200, "R1", "element 3 of gather", rf[1][3], 200);
        chk(rf[1][4] == 32'hDEAD_0014, "R3", "element 4 untouched",
            rf[1][4], 32'hDEAD_0014);
        run_op(1'b1, 4, 100, 0, 2, 1, 1'b0, "R2 case scatter");
        chk(mem[107] == 400, "R2", "word 107", mem[107], 400);
        chk(mem[100] == 500, "R2", "word 100", mem[100], 500);
        chk(mem[101] == 300, "R3", "word 101 untouched", mem[101], 300);

        // Zero length both ways
        run_op(1'b0, 0, 50, 0, 2, 1, 1'b0, "R8 zero gather");
        run_op(1'b1, 0, 50, 0, 2, 1, 1'b0, "R8 zero scatter");

        // Duplicate scatter targets: highest element wins
        rf[3][0] = 3; rf[3][1] = 3; rf[3][2] = 5; rf[3][3] = 3;
        rf[2][0] = 11; rf[2][1] = 22; rf[2][2] = 33; rf[2][3] = 44;
        gnt_all = 1'b0;
        run_op(1'b1, 4, 600, 3, 2, 1, 1'b0, "R6 duplicate scatter");
        chk(mem[603] == 44, "R6", "duplicate target keeps last", mem[603], 44);
        chk(mem[605] == 33, "R6", "single target", mem[605], 33);

        // Start ignored while busy
        run_op(1'b0, 6, 300, 0, 2, 1, 1'b1, "R9 poke gather");
        run_op(1'b1, 6, 320, 0, 2, 1, 1'b1, "R9 poke scatter");

        // Sweep: both ops, both grant patterns, every length incl. over-long
        for (int g = 0; g < 2; g++) begin
            for (int s = 0; s < 2; s++) begin
                for (int v = 0; v <= MVL + 2; v++) begin
                    int vv = (v == MVL + 2) ? 15 : v;
                    gnt_all = g[0];
                    for (int e = 0; e < MVL; e++) begin
                        rf[0][e] = DW'((e * 5 + vv * 3 + s) % 37);
                        rf[2][e] = DW'(1000 + vv * 16 + e + g * 512);
                    end
                    run_op(s[0], vv, (vv * 61 + s * 300) % 900, 0, 2, 1, 1'b0,
                           (vv > MVL) ? "R11 sweep" : "R4 sweep");
                end
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule